// File: doc/BRIEF.md
# Machine Status Control Register

This block keeps the machine-level status word of a small 32-bit core. The word holds the global interrupt enable, a saved copy of that enable, the privilege level that was active before the last trap, an override that makes loads and stores run at the saved privilege, and a flag that makes a wait-for-interrupt issued from user level illegal. The block also keeps the current privilege level of the hart.

The status word changes in three ways. The pipeline can write it through the CSR access port, as a plain write, a bit set or a bit clear. The trap logic can signal trap entry. The trap logic can also signal a return from a trap. From this state the block drives the current privilege, the effective privilege for data accesses and a flag for an illegal wait-for-interrupt. A build parameter removes user-level support. In that build the user-related fields are fixed and the hart stays at machine level.

Top module: `msr_unit`

## Requirements
- R1: A read with `csr_en` high and `csr_addr` equal to 0x300 returns the status word on `csr_rdata`. Any other address, or `csr_en` low, returns zero and leaves the state unchanged.
- R2: The status word has this layout. Bit 3 is the interrupt enable and bit 7 is the saved enable. Bits 12:11 are the saved privilege, bit 17 is the data-privilege override and bit 21 is the WFI-trap flag. Every other bit reads as zero.
- R3: After reset the word reads 0x00001800 and `cur_priv` is 2'b11 (machine).
- R4: The saved-privilege field encodes user as 2'b00 and machine as 2'b11. A write result of 2'b01 or 2'b10 stores 2'b11.
- R5: `csr_op` selects how a hit is handled. The value 0 only reads. The value 1 replaces the word with `csr_wdata`. The value 2 ORs `csr_wdata` into the word. The value 3 clears the bits that are set in `csr_wdata`.
- R6: On trap entry the saved enable takes the old enable and the enable clears. The saved privilege takes the current privilege, and the current privilege becomes machine.
- R7: On trap return the enable takes the saved enable, the saved enable becomes 1 and the privilege takes the saved privilege. The saved privilege then becomes user. If the restored level is user, the override clears.
- R8: Trap entry wins over trap return in the same cycle. Either event wins over a CSR write in the same cycle, and that write is dropped.
- R9: `eff_priv` equals the saved privilege when the override bit is set. Otherwise it equals `cur_priv`.
- R10: `wfi_illegal` is high exactly when `wfi_exec` is high, the privilege is user and the WFI-trap flag is set.
- R11: With `USER_EN` = 0, bits 17 and 21 read zero and ignore writes. Bits 12:11 always read 2'b11. `cur_priv` and `eff_priv` stay at machine, and `wfi_illegal` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | CSR access valid this cycle |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | 0 read, 1 write, 2 set bits, 3 clear bits |
| csr_wdata | input | 32 | Write operand |
| csr_rdata | output | 32 | Read data (zero on a miss) |
| trap_enter | input | 1 | Trap taken this cycle |
| trap_return | input | 1 | Return from trap this cycle |
| wfi_exec | input | 1 | A wait-for-interrupt is executing |
| cur_priv | output | 2 | Current privilege (11 machine, 00 user) |
| eff_priv | output | 2 | Privilege for loads and stores |
| wfi_illegal | output | 1 | The executing wait-for-interrupt must trap |

## Verification
Some properties are checked on every cycle. These cover the zero read on a miss, the zero unimplemented bits and the legal encodings of the saved privilege. They also cover the field moves after trap entry and trap return, and entry winning over a same-cycle write. They further check that `wfi_illegal` occurs only at user level, that the effective privilege follows the current one while the override is clear, and that the machine-only build stays fixed. The bench's sweeps are needed for the exact merge results of the three write operations over all field patterns and for the mapping of 01 and 10 to machine. They are also needed for the ordering of simultaneous events and for entering user level through a trap return and leaving it through trap entry.

// File: rtl/msr_pkg.sv
package msr_pkg;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_M = 2'b11;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  localparam int POS_IE   = 3;
  localparam int POS_PIE  = 7;
  localparam int POS_PP   = 11;
  localparam int POS_OVR  = 17;
  localparam int POS_WFIT = 21;

  localparam logic [31:0] IMPL_MASK =
    (32'd1 << POS_IE) | (32'd1 << POS_PIE) | (32'd3 << POS_PP) |
    (32'd1 << POS_OVR) | (32'd1 << POS_WFIT);

  typedef struct packed {
    logic ie;
    logic pie;
    logic pp_m;
    logic ovr;
    logic wfit;
  } msr_fields_t;

  function automatic logic [31:0] msr_pack(input msr_fields_t f);
    logic [31:0] w;
    w = '0;
    w[POS_IE]        = f.ie;
    w[POS_PIE]       = f.pie;
    w[POS_PP +: 2]   = f.pp_m ? PRIV_M : PRIV_U;
    w[POS_OVR]       = f.ovr;
    w[POS_WFIT]      = f.wfit;
    return w;
  endfunction

  function automatic msr_fields_t msr_unpack(input logic [31:0] w);
    msr_fields_t f;
    f.ie   = w[POS_IE];
    f.pie  = w[POS_PIE];
    f.pp_m = |w[POS_PP +: 2];
    f.ovr  = w[POS_OVR];
    f.wfit = w[POS_WFIT];
    return f;
  endfunction

  function automatic logic [31:0] msr_merge(input csr_op_e op,
                                            input logic [31:0] cur,
                                            input logic [31:0] opnd);
    case (op)
      OP_WRITE: return opnd;
      OP_SET:   return cur | opnd;
      OP_CLEAR: return cur & ~opnd;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/msr_csr_port.sv
module msr_csr_port
  import msr_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] CSR_ADDR = 12'h300,
  parameter bit          USER_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_en,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [1:0]        csr_op,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic [31:0]       cur_word,
  output logic              wr_req,
  output msr_fields_t       wr_fields,
  output logic [XLEN-1:0]   csr_rdata
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CSR_ADDR);

  logic        hit;
  csr_op_e     op;
  logic [31:0] merged;

  assign op        = csr_op_e'(csr_op);
  assign hit       = csr_en && (csr_addr == HIT_ADDR);
  assign wr_req    = hit && (op != OP_READ);
  assign merged    = msr_merge(op, cur_word, 32'(csr_wdata));
  assign wr_fields = msr_unpack(merged);
  assign csr_rdata = hit ? XLEN'(cur_word) : '0;

  a_r1_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_en && (csr_addr == HIT_ADDR)) |-> (csr_rdata == '0));

  a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(csr_rdata) & ~IMPL_MASK) == 32'd0);

  a_r4_pp_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_word[POS_PP +: 2] == PRIV_U) || (cur_word[POS_PP +: 2] == PRIV_M));

  generate
    if (!USER_EN) begin : g_mo_chk
      a_r11_fixed_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_word[POS_PP +: 2] == PRIV_M) && !cur_word[POS_OVR] && !cur_word[POS_WFIT]);
    end
  endgenerate

endmodule

// File: rtl/msr_state.sv
module msr_state
  import msr_pkg::*;
#(
  parameter bit USER_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trap_enter,
  input  logic        trap_return,
  input  logic        wr_req,
  input  msr_fields_t wr_fields,
  output msr_fields_t fields,
  output logic        priv_m
);

  logic ev_trap, ev_ret, ev_wr;
  logic ie_q, pie_q, pp_m_q, ovr_q, wfit_q, priv_m_q;

  assign ev_trap = trap_enter;
  assign ev_ret  = trap_return && !trap_enter;
  assign ev_wr   = wr_req && !trap_enter && !trap_return;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      pie_q <= 1'b0;
    end else if (ev_trap) begin
      pie_q <= ie_q;
      ie_q  <= 1'b0;
    end else if (ev_ret) begin
      ie_q  <= pie_q;
      pie_q <= 1'b1;
    end else if (ev_wr) begin
      ie_q  <= wr_fields.ie;
      pie_q <= wr_fields.pie;
    end
  end

  generate
    if (USER_EN) begin : g_user
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pp_m_q   <= 1'b1;
          ovr_q    <= 1'b0;
          wfit_q   <= 1'b0;
          priv_m_q <= 1'b1;
        end else if (ev_trap) begin
          pp_m_q   <= priv_m_q;
          priv_m_q <= 1'b1;
        end else if (ev_ret) begin
          priv_m_q <= pp_m_q;
          pp_m_q   <= 1'b0;
          if (!pp_m_q) ovr_q <= 1'b0;
        end else if (ev_wr) begin
          pp_m_q <= wr_fields.pp_m;
          ovr_q  <= wr_fields.ovr;
          wfit_q <= wr_fields.wfit;
        end
      end

      a_r6_priv_saved: assert property (@(posedge clk) disable iff (!rst_n)
        ev_trap |=> (priv_m_q && (pp_m_q == $past(priv_m_q))));

      a_r7_priv_restored: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ret |=> ((priv_m_q == $past(pp_m_q)) && !pp_m_q));

      a_r7_user_drops_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ret && !pp_m_q) |=> !ovr_q);
    end else begin : g_mach_only
      logic unused_wr;
      assign unused_wr = wr_fields.pp_m ^ wr_fields.ovr ^ wr_fields.wfit;
      assign pp_m_q   = 1'b1;
      assign ovr_q    = 1'b0;
      assign wfit_q   = 1'b0;
      assign priv_m_q = 1'b1;
    end
  endgenerate

  assign fields = '{ie: ie_q, pie: pie_q, pp_m: pp_m_q, ovr: ovr_q, wfit: wfit_q};
  assign priv_m = priv_m_q;

  a_r6_enable_saved: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter |=> (!ie_q && (pie_q == $past(ie_q))));

  a_r7_enable_restored: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_return && !trap_enter) |=> (pie_q && (ie_q == $past(pie_q))));

  a_r8_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_enter && wr_req) |=> !ie_q);

endmodule

// File: rtl/msr_priv_eval.sv
module msr_priv_eval
  import msr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       priv_m,
  input  logic       pp_m,
  input  logic       ovr,
  input  logic       wfit,
  input  logic       wfi_exec,
  output logic [1:0] cur_priv,
  output logic [1:0] eff_priv,
  output logic       wfi_illegal
);

  function automatic logic [1:0] enc_priv(input logic is_m);
    return is_m ? PRIV_M : PRIV_U;
  endfunction

  assign cur_priv    = enc_priv(priv_m);
  assign eff_priv    = enc_priv(ovr ? pp_m : priv_m);
  assign wfi_illegal = wfi_exec && !priv_m && wfit;

  a_r9_plain_eff: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr |-> (eff_priv == cur_priv));

  a_r10_only_user: assert property (@(posedge clk) disable iff (!rst_n)
    wfi_illegal |-> (cur_priv == PRIV_U));

  a_r10_needs_wfi: assert property (@(posedge clk) disable iff (!rst_n)
    !wfi_exec |-> !wfi_illegal);

endmodule

// File: rtl/msr_unit.sv
module msr_unit
  import msr_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] CSR_ADDR = 12'h300,
  parameter bit          USER_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_en,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [1:0]        csr_op,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic              trap_enter,
  input  logic              trap_return,
  input  logic              wfi_exec,
  output logic [1:0]        cur_priv,
  output logic [1:0]        eff_priv,
  output logic              wfi_illegal
);

  msr_fields_t fields, wr_fields;
  logic        wr_req, priv_m;
  logic [31:0] cur_word;

  assign cur_word = msr_pack(fields);

  msr_csr_port #(
    .XLEN(XLEN), .ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR), .USER_EN(USER_EN)
  ) u_port (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_addr(csr_addr),
    .csr_op(csr_op), .csr_wdata(csr_wdata), .cur_word(cur_word),
    .wr_req(wr_req), .wr_fields(wr_fields), .csr_rdata(csr_rdata)
  );

  msr_state #(.USER_EN(USER_EN)) u_state (
    .clk(clk), .rst_n(rst_n), .trap_enter(trap_enter),
    .trap_return(trap_return), .wr_req(wr_req), .wr_fields(wr_fields),
    .fields(fields), .priv_m(priv_m)
  );

  msr_priv_eval u_eval (
    .clk(clk), .rst_n(rst_n), .priv_m(priv_m), .pp_m(fields.pp_m),
    .ovr(fields.ovr), .wfit(fields.wfit), .wfi_exec(wfi_exec),
    .cur_priv(cur_priv), .eff_priv(eff_priv), .wfi_illegal(wfi_illegal)
  );

  generate
    if (!USER_EN) begin : g_mo_out
      a_r11_stays_machine: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv == PRIV_M) && (eff_priv == PRIV_M) && !wfi_illegal);
    end
  endgenerate

endmodule

// File: tb/msr_unit_bench.sv
module msr_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_en = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  csr_op = '0;
  logic [31:0] csr_wdata = '0;
  logic        trap_enter = 1'b0, trap_return = 1'b0, wfi_exec = 1'b0;
  logic [31:0] rd_u, rd_n;
  logic [1:0]  cp_u, ep_u, cp_n, ep_n;
  logic        wi_u, wi_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  msr_unit u_msr_unit (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_addr(csr_addr),
    .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_rdata(rd_u),
    .trap_enter(trap_enter), .trap_return(trap_return), .wfi_exec(wfi_exec),
    .cur_priv(cp_u), .eff_priv(ep_u), .wfi_illegal(wi_u)
  );

  msr_unit #(.USER_EN(1'b0)) u_msr_unit_mo (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_addr(csr_addr),
    .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_rdata(rd_n),
    .trap_enter(trap_enter), .trap_return(trap_return), .wfi_exec(wfi_exec),
    .cur_priv(cp_n), .eff_priv(ep_n), .wfi_illegal(wi_n)
  );

  // reference state, user-capable instance
  logic       m_ie = 0, m_pie = 0, m_ovr = 0, m_wfit = 0;
  logic [1:0] m_pp = 2'b11, m_priv = 2'b11;
  // reference state, machine-only instance
  logic       n_ie = 0, n_pie = 0;

  function automatic logic [31:0] word_u();
    return (32'(m_ie) * 8) + (32'(m_pie) * 128) + (32'(m_pp) * 2048) +
           (32'(m_ovr) * 131072) + (32'(m_wfit) * 2097152);
  endfunction

  function automatic logic [31:0] word_n();
    return (32'(n_ie) * 8) + (32'(n_pie) * 128) + 32'h1800;
  endfunction

  function automatic logic [31:0] spread(input int i);
    return (32'(i & 1) << 3) | (32'((i >> 1) & 1) << 7) | (32'((i >> 2) & 3) << 11) |
           (32'((i >> 4) & 1) << 17) | (32'((i >> 5) & 1) << 21);
  endfunction

  function automatic logic [31:0] apply_op(input logic [1:0] op, input logic [31:0] c,
                                           input logic [31:0] w);
    if (op == 2'd1) return w;
    if (op == 2'd2) return c | w;
    return c & ~w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic en, input logic [11:0] a,
                      input logic [1:0] op, input logic [31:0] w,
                      input logic te, input logic tr, input logic wf);
    logic       hit;
    logic [31:0] v;
    logic [1:0]  old_pp;
    @(negedge clk);
    csr_en = en; csr_addr = a; csr_op = op; csr_wdata = w;
    trap_enter = te; trap_return = tr; wfi_exec = wf;
    #2;
    hit = en && (a == 12'h300);
    chk(tag, rd_u, hit ? word_u() : 32'd0);
    chk(tag, 32'(cp_u), 32'(m_priv));
    chk("R9", 32'(ep_u), 32'(m_ovr ? m_pp : m_priv));
    chk("R10", 32'(wi_u), 32'(wf && (m_priv == 2'b00) && m_wfit));
    chk("R11", rd_n, hit ? word_n() : 32'd0);
    chk("R11", {28'd0, cp_n, ep_n}, 32'hF);
    chk("R11", 32'(wi_n), 32'd0);
    @(posedge clk);
    if (te) begin
      m_pie = m_ie; m_ie = 0; m_pp = m_priv; m_priv = 2'b11;
      n_pie = n_ie; n_ie = 0;
    end else if (tr) begin
      old_pp = m_pp;
      m_priv = old_pp; m_ie = m_pie; m_pie = 1; m_pp = 2'b00;
      if (old_pp == 2'b00) m_ovr = 0;
      n_ie = n_pie; n_pie = 1;
    end else if (hit && op != 2'd0) begin
      v = apply_op(op, word_u(), w);
      m_ie = v[3]; m_pie = v[7]; m_pp = (v[12:11] == 2'b00) ? 2'b00 : 2'b11;
      m_ovr = v[17]; m_wfit = v[21];
      v = apply_op(op, word_n(), w);
      n_ie = v[3]; n_pie = v[7];
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R3: reset value and privilege
    step("R3", 1, 12'h300, 2'd0, 32'hFFFF_FFFF, 0, 0, 1);
    chk("R3", word_u(), 32'h0000_1800);
    // R2: all ones written, only implemented bits come back
    step("R2", 1, 12'h300, 2'd1, 32'hFFFF_FFFF, 0, 0, 0);
    step("R2", 1, 12'h300, 2'd0, 32'h0, 0, 0, 0);
    // R4: every saved-privilege encoding
    for (int e = 0; e < 4; e++) begin
      step("R4", 1, 12'h300, 2'd1, 32'(e) << 11, 0, 0, 0);
      step("R4", 1, 12'h300, 2'd0, 32'h0, 0, 0, 0);
    end
    // R5 / R1: all ops over all field patterns, plus misses
    for (int op = 0; op < 4; op++) begin
      for (int i = 0; i < 64; i++) begin
        logic [31:0] w;
        w = spread(i) | (32'(i * 32'h9E3779B1) & ~32'h0022_1888);
        step("R5", 1, 12'h300, 2'(op), w, 0, 0, 1);
        step("R1", 1, 12'h301 + 12'(i), 2'd1, ~w, 0, 0, 0);
        step("R1", 0, 12'h300, 2'd1, ~w, 0, 0, 0);
      end
    end
    // R6 / R7 / R8: events from every field state, at both privileges
    for (int i = 0; i < 64; i++) begin
      for (int k = 0; k < 5; k++) begin
        step("R7", 1, 12'h300, 2'd1, spread(i), 0, 0, 1);
        if (i & 8) step("R7", 0, 12'h0, 2'd0, 32'h0, 0, 1, 1);
        step("R5", 1, 12'h300, 2'd1, spread(i ^ k), 0, 0, 1);
        case (k)
          0: step("R6", 0, 12'h0, 2'd0, 32'h0, 1, 0, 1);
          1: step("R7", 0, 12'h0, 2'd0, 32'h0, 0, 1, 1);
          2: step("R8", 0, 12'h0, 2'd0, 32'h0, 1, 1, 1);
          3: step("R8", 1, 12'h300, 2'd1, 32'hFFFF_FFFF, 1, 0, 1);
          default: step("R8", 1, 12'h300, 2'd1, 32'hFFFF_FFFF, 0, 1, 1);
        endcase
        step("R6", 1, 12'h300, 2'd0, 32'h0, 0, 0, 1);
      end
    end
    finish_run();
  end

endmodule